// File: doc/BRIEF.md
# Single-Cycle Processor Core

This block is a 32-bit load/store processor core that retires one instruction on every rising clock edge. It supports three register-to-register arithmetic operations (add, subtract, signed set-less-than), a word load, a word store and a branch taken on equality. Decoding has two levels. A main decoder turns the 6-bit opcode into datapath controls and a 2-bit ALU class. An ALU-control stage combines that class with the function field.

The core has two memory ports. The instruction port carries the program counter as a byte address that is always a multiple of 4, and takes back the addressed word in the same cycle. The data port carries a byte address, write data, and separate read and write enables, and takes read data back in the same cycle. The core writes the register file and the program counter at the clock edge that ends each instruction. The branch target adder runs in parallel with the ALU.

Top module: `scp_core`

## Requirements
- R1: While rst_ni is low the instruction address output is 0, and execution starts from address 0 after release.
- R2: Every instruction other than a taken branch moves the instruction address forward by 4 at the next rising edge.
- R3: Opcode 100011 (bits 31:26) reads data memory at the rs register (bits 25:21) plus the sign-extended bits 15:0, with the read enable high and the write enable low. The loaded word goes to the rt register (bits 20:16).
- R4: Opcode 101011 drives the write enable for one cycle, the address rs plus the sign-extended bits 15:0 (negative offsets included), and the rt register as write data.
- R5: Opcode 000000 with function bits 5:0 equal to 100000 writes rs+rt to the rd register (bits 15:11). Function 100010 writes rs-rt.
- R6: Opcode 000000 with function 100100 writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R7: Opcode 000100 branches when rs equals rt. The next address is the current address plus 4 plus the sign-extended bits 15:0 shifted left by 2, and negative offsets work. When rs differs from rt, the address advances by 4.
- R8: Register 0 always reads as zero, and a result aimed at it is discarded.
- R9: Any other opcode changes no register and no memory: both data enables stay low and the address advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Instruction byte address (program counter) |
| imem_rdata_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_re_o | output | 1 | Data read enable |
| dmem_we_o | output | 1 | Data write enable |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o |

## Verification
The data-port outputs are combinational in the current instruction, so address, enables and store data are valid in the cycle that instruction is presented. Register results and the next program counter appear one rising edge later. A register result is therefore only visible through a later store, and the bench samples everything at the falling edge that follows each rising edge. The bench applies stores to its data model at that falling edge, after sampling. A short program runs over an 8x8 grid of signed corner operands. Final memory contents and the halt address are compared with sums, differences and signed comparisons that the bench computes itself.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_SLT = 6'b100100;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10
  } alu_cls_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     rf_we;
    logic     mem_re;
    logic     mem_we;
    logic     is_beq;
    alu_cls_e cls;
  } ctrl_t;
endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output alu_fn_e    fn_o
);
  always_comb begin
    ctrl_o = '{dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, rf_we: 1'b0,
               mem_re: 1'b0, mem_we: 1'b0, is_beq: 1'b0, cls: CLS_ADD};
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.cls    = CLS_FUNC;
      end
      OP_LOAD: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.mem_re  = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.is_beq = 1'b1;
        ctrl_o.cls    = CLS_SUB;
      end
      default: ;
    endcase
  end

  // second level: class plus function field
  always_comb begin
    unique case (ctrl_o.cls)
      CLS_SUB:  fn_o = ALU_SUB;
      CLS_FUNC: begin
        unique case (funct_i)
          FN_SUB:  fn_o = ALU_SUB;
          FN_SLT:  fn_o = ALU_SLT;
          default: fn_o = ALU_ADD;
        endcase
      end
      default:  fn_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] rows_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) rows_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      rows_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = (ra_a_i == '0) ? '0 : rows_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : rows_q[ra_b_i];
endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_fn_e      fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  logic [W-1:0] diff;
  logic         lt;

  assign diff = a_i - b_i;
  // signed compare from sign bits and the difference
  assign lt = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : diff[W-1];

  always_comb begin
    unique case (fn_i)
      ALU_SUB: y_o = diff;
      ALU_SLT: y_o = {{(W-1){1'b0}}, lt};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_re_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  logic [XLEN-1:0] pc_q, pc_d, pc_inc, pc_br;
  logic [5:0]      opcode, funct;
  logic [AW-1:0]   rs_a, rt_a, rd_a, wr_a;
  logic [15:0]     imm;
  logic [XLEN-1:0] imm_sx;
  ctrl_t           ctrl;
  alu_fn_e         fn;
  logic [XLEN-1:0] rs_data, rt_data, alu_b, alu_y, wb_data;
  logic            alu_zero;
  logic            unused_shamt;

  assign opcode = imem_rdata_i[31:26];
  assign rs_a   = AW'(imem_rdata_i[25:21]);
  assign rt_a   = AW'(imem_rdata_i[20:16]);
  assign rd_a   = AW'(imem_rdata_i[15:11]);
  assign funct  = imem_rdata_i[5:0];
  assign imm    = imem_rdata_i[15:0];
  assign unused_shamt = ^imem_rdata_i[10:6];

  assign imm_sx = {{(XLEN-16){imm[15]}}, imm};

  scp_decode u_dec (
    .opcode_i (opcode),
    .funct_i  (funct),
    .ctrl_o   (ctrl),
    .fn_o     (fn)
  );

  scp_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (rs_a),
    .ra_b_i (rt_a),
    .rd_a_o (rs_data),
    .rd_b_o (rt_data),
    .we_i   (ctrl.rf_we),
    .wa_i   (wr_a),
    .wd_i   (wb_data)
  );

  assign alu_b = ctrl.src_imm ? imm_sx : rt_data;

  scp_alu #(.W(XLEN)) u_alu (
    .fn_i   (fn),
    .a_i    (rs_data),
    .b_i    (alu_b),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign wr_a    = ctrl.dst_rd ? rd_a : rt_a;
  assign wb_data = ctrl.wb_mem ? dmem_rdata_i : alu_y;

  // branch target built beside the ALU, not through it
  assign pc_inc = pc_q + XLEN'(4);
  assign pc_br  = pc_inc + {imm_sx[XLEN-3:0], 2'b00};
  assign pc_d   = (ctrl.is_beq && alu_zero) ? pc_br : pc_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_data;
  assign dmem_re_o    = ctrl.mem_re;
  assign dmem_we_o    = ctrl.mem_we;
endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] instr_i,
  input logic [31:0] pc_i,
  input logic [31:0] rs_data_i,
  input logic [31:0] rt_data_i,
  input logic [31:0] dmem_addr_i,
  input logic [31:0] dmem_wdata_i,
  input logic        dmem_re_i,
  input logic        dmem_we_i
);
  logic [5:0]  op;
  logic [31:0] sx;
  assign op = instr_i[31:26];
  assign sx = {{16{instr_i[15]}}, instr_i[15:0]};

  AST_RESET_PC: assert property (@(posedge clk_i) !rst_ni |-> pc_i == 32'd0); // R1
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 6'b000100) |=> pc_i == $past(pc_i) + 32'd4); // R2
  AST_LOAD_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'b100011) |-> dmem_re_i && !dmem_we_i && dmem_addr_i == rs_data_i + sx); // R3
  AST_STORE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'b101011) |-> dmem_we_i && dmem_addr_i == rs_data_i + sx && dmem_wdata_i == rt_data_i); // R4
  AST_BEQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'b000100 && rs_data_i == rt_data_i) |=> pc_i == $past(pc_i) + 32'd4 + {$past(sx[29:0]), 2'b00}); // R7
  AST_BEQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'b000100 && rs_data_i != rt_data_i) |=> pc_i == $past(pc_i) + 32'd4); // R7
  AST_REG0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[25:21] == 5'd0) |-> rs_data_i == 32'd0); // R8
  AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 6'b101011) |-> !dmem_we_i); // R9
endmodule

bind scp_core scp_core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_i      (imem_rdata_i),
  .pc_i         (imem_addr_o),
  .rs_data_i    (rs_data),
  .rt_data_i    (rt_data),
  .dmem_addr_i  (dmem_addr_o),
  .dmem_wdata_i (dmem_wdata_o),
  .dmem_re_i    (dmem_re_o),
  .dmem_we_i    (dmem_we_o)
);

// File: tb/scp_core_tb.sv
`timescale 1ns/1ps
module scp_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr_o, imem_rdata_i;
  logic [31:0] dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        dmem_re_o, dmem_we_o;

  logic [31:0] imem [64];
  logic [31:0] dmem [16];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cycles <= cycles + 1;

  assign imem_rdata_i = imem[imem_addr_o[7:2]];
  assign dmem_rdata_i = dmem[dmem_addr_o[5:2]];

  scp_core u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr_o),
    .imem_rdata_i (imem_rdata_i),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_wdata_o (dmem_wdata_o),
    .dmem_re_o    (dmem_re_o),
    .dmem_we_o    (dmem_we_o),
    .dmem_rdata_i (dmem_rdata_i)
  );

  function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BQ = 6'b000100;

  task automatic load_prog();
    for (int i = 0; i < 64; i++) imem[i] = 32'd0;
    imem[0]  = itype(LW, 0, 1, 0);
    imem[1]  = itype(LW, 0, 2, 4);
    imem[2]  = itype(LW, 0, 7, 8);
    imem[3]  = rtype(1, 2, 3, 6'b100000);
    imem[4]  = rtype(1, 2, 4, 6'b100010);
    imem[5]  = rtype(1, 2, 5, 6'b100100);
    imem[6]  = itype(SW, 0, 3, 12);
    imem[7]  = itype(SW, 0, 4, 16);
    imem[8]  = itype(SW, 0, 5, 20);
    imem[9]  = rtype(1, 2, 0, 6'b100000);
    imem[10] = itype(6'b001000, 0, 1, 5);
    imem[11] = itype(SW, 0, 0, 24);
    imem[12] = itype(SW, 7, 3, -8);
    imem[13] = itype(SW, 0, 1, 28);
    imem[14] = itype(BQ, 1, 2, 2);
    imem[15] = itype(SW, 0, 2, 36);
    imem[16] = itype(BQ, 0, 0, -1);
    imem[17] = itype(SW, 0, 1, 40);
    imem[18] = itype(BQ, 0, 0, -1);
  endtask

  localparam logic [31:0] SENT = 32'hA5A5_0000;

  task automatic run_case(logic [31:0] a, logic [31:0] b);
    logic [31:0] slt_e;
    rst_ni = 1'b0;
    for (int i = 0; i < 16; i++) dmem[i] = SENT + 32'(i);
    dmem[0] = a;
    dmem[1] = b;
    dmem[2] = 32'd40;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 reset pc", imem_addr_o, 32'd0);
    rst_ni = 1'b1;
    for (int c = 0; c < 30; c++) begin
      if (imem_addr_o == 32'd0) begin
        chk("R3 load enable", {31'd0, dmem_re_o & ~dmem_we_o}, 32'd1);
        chk("R3 load addr", dmem_addr_o, 32'd0);
      end
      if (imem_addr_o == 32'd40)
        chk("R9 no mem access", {30'd0, dmem_re_o, dmem_we_o}, 32'd0);
      if (imem_addr_o == 32'd48) begin
        chk("R4 store neg offset addr", dmem_addr_o, 32'd32);
        chk("R4 store enable", {31'd0, dmem_we_o}, 32'd1);
      end
      if (dmem_we_o) dmem[dmem_addr_o[5:2]] = dmem_wdata_o;
      @(negedge clk_i);
    end
    slt_e = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    chk("R5 add", dmem[3], a + b);
    chk("R5 sub", dmem[4], a - b);
    chk("R6 slt signed", dmem[5], slt_e);
    chk("R8 reg0 write dropped", dmem[6], 32'd0);
    chk("R9 unknown op kept rt", dmem[7], a);
    chk("R4 store via base", dmem[8], a + b);
    if (a == b) begin
      chk("R7 taken marker", dmem[10], a);
      chk("R7 skipped slot", dmem[9], SENT + 32'd9);
      chk("R7 halt pc taken", imem_addr_o, 32'd72);
    end else begin
      chk("R7 fall marker", dmem[9], b);
      chk("R7 untaken slot", dmem[10], SENT + 32'd10);
      chk("R2 halt pc fall", imem_addr_o, 32'd64);
    end
  endtask

  initial begin
    logic [31:0] vals [8];
    vals[0] = 32'd0;          vals[1] = 32'd1;
    vals[2] = 32'hFFFF_FFFF;  vals[3] = 32'd7;
    vals[4] = 32'h7FFF_FFFF;  vals[5] = 32'h8000_0000;
    vals[6] = 32'd5;          vals[7] = 32'hFFFF_FFFB;
    load_prog();
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_case(vals[i], vals[j]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule